// File: doc/BRIEF.md
# Receive Frame Parser with CRC Check

This block sits behind a demodulator and takes in received bytes, one per `byteValid` strobe. It looks for a run of four zero bytes, then the start-of-frame code 0xA7, then a length byte. It then writes that many bytes (the payload followed by the two-byte check sequence) into a local byte RAM and runs a 16-bit CRC over them as they arrive. At the last byte it reports whether the CRC residue is zero.

The host chooses between two ways of being told about a frame. In packet mode it gets one interrupt pulse when the whole frame is in RAM, and it then reads the bytes through a combinational read port. In streaming mode it gets one interrupt for every 16-bit word and reads the word from a holding register. It acknowledges each word, and a missed acknowledge is reported as an overrun. The block also measures link quality. When a full preamble has been seen, it opens a 64 µs window, counted in clock cycles from a clock-frequency parameter. It tracks the peak of an incoming level sample over that window and latches the peak when the window closes.

Top module: `frame_rx_parser`

## Requirements
- R1: A frame starts only after four consecutive 0x00 bytes followed by 0xA7. A non-zero byte seen before the fourth zero sets the zero count back to none.
- R2: After a full preamble, any byte other than 0xA7 restarts the preamble search without any interrupt or frame-done pulse. A 0x00 byte in that position counts as the first zero of the new search, so six zeros followed by 0xA7 are rejected and eight zeros followed by 0xA7 are accepted.
- R3: The byte after 0xA7 is the length. Values from 3 to 127 are accepted and `frameLen` takes that value. Values 0 to 2 and 128 to 255 drop the frame with no frame-done pulse, and the parser goes back to hunting.
- R4: The length bytes after the length byte are written to RAM addresses 0 through length-1, in arrival order. Any address can be read through `ramRdAddr`/`ramRdData` with no added latency.
- R5: The CRC uses the polynomial x^16+x^12+x^5+1, processed bit-reflected (least significant bit of each byte first), with an initial value of 0 and no final inversion. It runs over every stored byte. `crcPass` is 1 when the result is zero, which holds when the check sequence is appended low byte first.
- R6: In packet mode (`streamMode`=0), exactly one `irq` pulse is raised per frame, in the cycle after the last byte is accepted. `frameDone` pulses in the same cycle, and `crcPass` becomes valid in that cycle.
- R7: In streaming mode, `irq` pulses in the cycle after every second stored byte, and `streamWord` = {second byte, first byte}. If the length is odd, the last byte raises its own `irq` with `streamWord` = {0x00, byte}.
- R8: In streaming mode, if a word completes while the previous word has not been acknowledged with `wordAck`, `overrun` is set. It stays set until the next 0xA7 is accepted. An acknowledge in the same cycle as a completion covers the older word.
- R9: When the fourth preamble zero is accepted, a window of CLK_FREQ_HZ/15625 cycles begins. When it ends, `lqiValue` takes the maximum `linkLevel` seen during the window and `lqiValid` pulses for one cycle. `lqiValue` holds between windows.
- R10: The streaming or packet choice is sampled when 0xA7 is accepted. Changing `streamMode` later in the frame has no effect on that frame.
- R11: After reset, `irq`, `frameDone`, `crcPass`, `frameLen`, `streamWord`, `overrun`, `lqiValue` and `lqiValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received byte is present on byteData |
| byteData | input | 8 | Received byte |
| streamMode | input | 1 | 1 = interrupt per word, 0 = interrupt per frame |
| linkLevel | input | 8 | Level sample used for link quality |
| wordAck | input | 1 | Host has taken the current streamWord |
| ramRdAddr | input | 7 | RAM read address |
| ramRdData | output | 8 | RAM read data (combinational) |
| irq | output | 1 | Interrupt pulse |
| frameDone | output | 1 | Pulse after the last byte of a frame |
| crcPass | output | 1 | CRC residue of the last frame was zero |
| frameLen | output | 8 | Length of the last accepted frame |
| streamWord | output | 16 | Most recent streaming word |
| overrun | output | 1 | A streaming word was lost |
| lqiValue | output | 8 | Peak level from the last window |
| lqiValid | output | 1 | Pulse when lqiValue is updated |

## Verification
The corner that is hardest to reach from the ports is the preamble restart after a complete preamble. A zero in that position must be counted as the start of a new search, and only a precise count of zero bytes in front of 0xA7 separates acceptance from rejection. The stimulus sends directed runs of six and eight zeros, and a run broken by a non-zero byte, ahead of 0xA7. Overrun is reached by switching off the bench's automatic acknowledge for one streaming frame. The next frame then checks that the flag clears exactly at its 0xA7. The link-quality window is exercised by stalling the byte stream well beyond the window and then raising the level, so a late peak must not appear in the result.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  localparam logic [7:0] SFD_CODE = 8'hA7;
  localparam logic [7:0] PRE_BYTE = 8'h00;
  localparam int PRE_COUNT = 4;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_LEN,
    ST_BODY
  } rxState_t;

  typedef struct packed {
    logic frameStart;
    logic store;
    logic lastByte;
    logic winStart;
  } rxStrobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] data);
    logic [15:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int MIN_LEN = 3,
  parameter int MAX_LEN = 127
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output rxStrobe_t         strobe,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [7:0]        frameLen
);

  localparam logic [7:0] MIN_L = 8'(MIN_LEN);
  localparam logic [7:0] MAX_L = 8'(MAX_LEN);
  localparam logic [2:0] PRE_FULL = 3'(PRE_COUNT);
  localparam logic [2:0] PRE_LAST = 3'(PRE_COUNT - 1);

  rxState_t          state;
  logic [2:0]        preCnt;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        lenReg;
  logic [7:0]        idxExt;
  logic              isZero;
  logic              lenOk;

  assign idxExt = 8'(idx);
  assign isZero = (byteData == PRE_BYTE);
  assign lenOk  = (byteData >= MIN_L) && (byteData <= MAX_L);

  always_comb begin
    strobe = '0;
    if (byteValid) begin
      unique case (state)
        ST_HUNT: begin
          if (preCnt == PRE_FULL && byteData == SFD_CODE) strobe.frameStart = 1'b1;
          else if (preCnt == PRE_LAST && isZero) strobe.winStart = 1'b1;
        end
        ST_BODY: begin
          strobe.store = 1'b1;
          strobe.lastByte = (idxExt == lenReg - 8'd1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      preCnt <= '0;
      idx    <= '0;
      lenReg <= '0;
    end else if (byteValid) begin
      unique case (state)
        ST_HUNT: begin
          if (preCnt == PRE_FULL) begin
            if (byteData == SFD_CODE) begin
              state  <= ST_LEN;
              preCnt <= '0;
            end else begin
              preCnt <= isZero ? 3'd1 : 3'd0;
            end
          end else begin
            preCnt <= isZero ? preCnt + 3'd1 : 3'd0;
          end
        end
        ST_LEN: begin
          if (lenOk) begin
            lenReg <= byteData;
            idx    <= '0;
            state  <= ST_BODY;
          end else begin
            state <= ST_HUNT;
          end
        end
        ST_BODY: begin
          idx <= idx + 1'b1;
          if (strobe.lastByte) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign storeAddr = idx;
  assign frameLen  = lenReg;

endmodule

// File: rtl/frame_rx_dp.sv
module frame_rx_dp
  import frame_rx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LQI_W = 8,
  parameter int WIN_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [7:0]        byteData,
  input  logic              streamMode,
  input  logic              wordAck,
  input  logic [LQI_W-1:0]  linkLevel,
  input  logic [ADDR_W-1:0] ramRdAddr,
  output logic [7:0]        ramRdData,
  output logic              irq,
  output logic              frameDone,
  output logic              crcPass,
  output logic [15:0]       streamWord,
  output logic              overrun,
  output logic [LQI_W-1:0]  lqiValue,
  output logic              lqiValid
);

  localparam int DEPTH = 2 ** ADDR_W;
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [15:0]      crcReg;
  logic [15:0]      crcNext;
  logic             modeReg;
  logic [7:0]       lowByte;
  logic             wordPending;
  logic             wordDone;
  logic [WIN_W-1:0] winCnt;
  logic [LQI_W-1:0] peak;
  logic [LQI_W-1:0] peakNext;

  always_ff @(posedge clk) begin
    if (strobe.store) mem[storeAddr] <= byteData;
  end
  assign ramRdData = mem[ramRdAddr];

  assign crcNext  = crcStep(crcReg, byteData);
  assign wordDone = strobe.store && modeReg && (storeAddr[0] || strobe.lastByte);
  assign peakNext = (linkLevel > peak) ? linkLevel : peak;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg      <= '0;
      modeReg     <= 1'b0;
      lowByte     <= '0;
      wordPending <= 1'b0;
      irq         <= 1'b0;
      frameDone   <= 1'b0;
      crcPass     <= 1'b0;
      streamWord  <= '0;
      overrun     <= 1'b0;
    end else begin
      irq       <= 1'b0;
      frameDone <= 1'b0;
      if (strobe.frameStart) begin
        crcReg      <= '0;
        modeReg     <= streamMode;
        overrun     <= 1'b0;
        wordPending <= 1'b0;
      end
      if (strobe.store) begin
        crcReg <= crcNext;
        if (!storeAddr[0]) lowByte <= byteData;
      end
      if (wordDone) begin
        streamWord  <= storeAddr[0] ? {byteData, lowByte} : {8'h00, byteData};
        irq         <= 1'b1;
        wordPending <= 1'b1;
        if (wordPending && !wordAck) overrun <= 1'b1;
      end else if (wordAck && !strobe.frameStart) begin
        wordPending <= 1'b0;
      end
      if (strobe.store && strobe.lastByte) begin
        frameDone <= 1'b1;
        crcPass   <= (crcNext == 16'h0000);
        if (!modeReg) irq <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt   <= '0;
      peak     <= '0;
      lqiValue <= '0;
      lqiValid <= 1'b0;
    end else begin
      lqiValid <= 1'b0;
      if (strobe.winStart) begin
        winCnt <= WIN_W'(WIN_CYCLES);
        peak   <= '0;
      end else if (winCnt != '0) begin
        peak   <= peakNext;
        winCnt <= winCnt - 1'b1;
        if (winCnt == WIN_W'(1)) begin
          lqiValue <= peakNext;
          lqiValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/frame_rx_parser.sv
module frame_rx_parser
  import frame_rx_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 16_000_000,
  parameter int MIN_LEN = 3,
  parameter int MAX_LEN = 127
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        streamMode,
  input  logic [7:0]  linkLevel,
  input  logic        wordAck,
  input  logic [6:0]  ramRdAddr,
  output logic [7:0]  ramRdData,
  output logic        irq,
  output logic        frameDone,
  output logic        crcPass,
  output logic [7:0]  frameLen,
  output logic [15:0] streamWord,
  output logic        overrun,
  output logic [7:0]  lqiValue,
  output logic        lqiValid
);

  localparam int ADDR_W = 7;
  localparam int WIN_RAW = CLK_FREQ_HZ / 15625;
  localparam int WIN_CYCLES = (WIN_RAW < 1) ? 1 : WIN_RAW;

  rxStrobe_t         strobe;
  logic [ADDR_W-1:0] storeAddr;

  frame_rx_ctrl #(
    .ADDR_W (ADDR_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .strobe   (strobe),
    .storeAddr(storeAddr),
    .frameLen (frameLen)
  );

  frame_rx_dp #(
    .ADDR_W    (ADDR_W),
    .LQI_W     (8),
    .WIN_CYCLES(WIN_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .storeAddr (storeAddr),
    .byteData  (byteData),
    .streamMode(streamMode),
    .wordAck   (wordAck),
    .linkLevel (linkLevel),
    .ramRdAddr (ramRdAddr),
    .ramRdData (ramRdData),
    .irq       (irq),
    .frameDone (frameDone),
    .crcPass   (crcPass),
    .streamWord(streamWord),
    .overrun   (overrun),
    .lqiValue  (lqiValue),
    .lqiValid  (lqiValid)
  );

endmodule

// File: rtl/frame_rx_parser_sva.sv
module frame_rx_parser_sva #(
  parameter int MIN_LEN = 3,
  parameter int MAX_LEN = 127
) (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic [7:0] byteData,
  input logic       irq,
  input logic       frameDone,
  input logic [7:0] frameLen,
  input logic       overrun,
  input logic [7:0] lqiValue,
  input logic       lqiValid
);

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(byteValid)); // R6

  AST_IRQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(byteValid)); // R7

  AST_DONE_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (frameLen >= 8'(MIN_LEN) && frameLen <= 8'(MAX_LEN))); // R3

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(byteValid && byteData == 8'hA7)) |=> overrun); // R8

  AST_LQI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lqiValid |-> $stable(lqiValue)); // R9

  AST_LQI_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    lqiValid |=> !lqiValid); // R9

endmodule

bind frame_rx_parser frame_rx_parser_sva #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_sva (.*);

// File: tb/test_frame_rx_parser.sv
module test_frame_rx_parser;

  localparam int CLK_PERIOD = 10;
  localparam int BENCH_CLK_HZ = 1_000_000;
  localparam int WIN = BENCH_CLK_HZ / 15625;

  logic        clk;
  logic        rstN;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        streamMode;
  logic [7:0]  linkLevel;
  logic        wordAck;
  logic [6:0]  ramRdAddr;
  logic [7:0]  ramRdData;
  logic        irq;
  logic        frameDone;
  logic        crcPass;
  logic [7:0]  frameLen;
  logic [15:0] streamWord;
  logic        overrun;
  logic [7:0]  lqiValue;
  logic        lqiValid;

  frame_rx_parser #(.CLK_FREQ_HZ(BENCH_CLK_HZ)) i_frame_rx_parser (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .streamMode(streamMode), .linkLevel(linkLevel), .wordAck(wordAck),
    .ramRdAddr(ramRdAddr), .ramRdData(ramRdData), .irq(irq), .frameDone(frameDone),
    .crcPass(crcPass), .frameLen(frameLen), .streamWord(streamWord), .overrun(overrun),
    .lqiValue(lqiValue), .lqiValid(lqiValid)
  );

  int checks = 0;
  int fails = 0;
  int irqCnt = 0;
  int doneCnt = 0;
  int lqiCnt = 0;
  int wordCnt = 0;
  bit ackOn = 1;
  logic [15:0] words [1024];
  logic [7:0] frm [128];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN) begin
      if (irq) irqCnt++;
      if (frameDone) doneCnt++;
      if (lqiValid) lqiCnt++;
      if (irq && wordCnt < 1024) begin
        words[wordCnt] = streamWord;
        wordCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
    if (ackOn && irq) begin
      wordAck = 1'b1;
      @(negedge clk);
      wordAck = 1'b0;
    end
  endtask

  task automatic sendPre();
    for (int i = 0; i < 4; i++) putByte(8'h00);
  endtask

  task automatic buildFrame(input int len, input bit corrupt);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 0; i < len - 2; i++) begin
      frm[i] = 8'($urandom);
      c = benchCrc(c, frm[i]);
    end
    frm[len-2] = c[7:0];
    frm[len-1] = c[15:8];
    if (corrupt) frm[0] = frm[0] ^ 8'h01;
  endtask

  // full frame with checks of R3..R7, R9, R10
  task automatic runFrame(input int len, input bit corrupt, input bit stream, input bit flip);
    int baseIrq, baseDone, baseWord, baseLqi;
    logic [7:0] lvl;
    buildFrame(len, corrupt);
    lvl = 8'($urandom);
    linkLevel = lvl;
    baseIrq = irqCnt; baseDone = doneCnt; baseWord = wordCnt; baseLqi = lqiCnt;
    streamMode = stream;
    sendPre();
    putByte(8'hA7);
    if (flip) streamMode = !stream;
    putByte(8'(len));
    for (int i = 0; i < len; i++) putByte(frm[i]);
    repeat (WIN + 6) @(negedge clk);
    #1;
    chk("R6 frameDone count", doneCnt - baseDone, 1);
    chk("R3 frameLen", frameLen, len);
    chk("R5 crcPass", crcPass, !corrupt);
    for (int i = 0; i < len; i++) begin
      ramRdAddr = 7'(i);
      #1;
      if (ramRdData !== frm[i]) chk("R4 RAM byte", ramRdData, frm[i]);
    end
    checks++;
    if (stream) begin
      chk(flip ? "R10 stream irq count" : "R7 irq count", irqCnt - baseIrq, (len + 1) / 2);
      for (int k = 0; k < len / 2; k++)
        chk("R7 stream word", words[baseWord + k], {frm[2*k+1], frm[2*k]});
      if (len % 2 == 1) chk("R7 odd tail word", words[baseWord + len/2], {8'h00, frm[len-1]});
      if (ackOn) chk("R8 no overrun when acked", overrun, 0);
    end else begin
      chk(flip ? "R10 packet irq count" : "R6 irq count", irqCnt - baseIrq, 1);
    end
    chk("R9 lqiValid count", lqiCnt - baseLqi, 1);
    chk("R9 lqiValue", lqiValue, lvl);
  endtask

  task automatic expectNoFrame(input string req, input int baseDone, input int baseIrq);
    repeat (4) @(negedge clk);
    #1;
    chk({req, " no frameDone"}, doneCnt - baseDone, 0);
    chk({req, " no irq"}, irqCnt - baseIrq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int bd, bi;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; byteValid = 1'b0; byteData = '0; streamMode = 1'b0;
    linkLevel = '0; wordAck = 1'b0; ramRdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 reset outputs",
        {irq, frameDone, crcPass, overrun, lqiValid, frameLen, streamWord, lqiValue}, 0);

    // directed boundaries
    runFrame(3, 0, 0, 0);
    runFrame(127, 0, 0, 0);
    runFrame(3, 0, 1, 0);
    runFrame(4, 1, 1, 0);
    runFrame(9, 0, 0, 1);   // R10 packet kept after flip
    runFrame(8, 0, 1, 1);   // R10 stream kept after flip

    // R1: broken preamble
    bd = doneCnt; bi = irqCnt;
    putByte(8'h00); putByte(8'h00); putByte(8'h00); putByte(8'hA7); putByte(8'h05);
    for (int i = 0; i < 5; i++) putByte(8'h11);
    expectNoFrame("R1 three zeros", bd, bi);
    bd = doneCnt; bi = irqCnt;
    putByte(8'h00); putByte(8'h00); putByte(8'h11); putByte(8'h00); putByte(8'h00);
    putByte(8'h00); putByte(8'hA7); putByte(8'h05);
    for (int i = 0; i < 5; i++) putByte(8'h11);
    expectNoFrame("R1 interrupted run", bd, bi);

    // R2: restart after full preamble
    bd = doneCnt; bi = irqCnt;
    sendPre(); putByte(8'h55); putByte(8'hA7); putByte(8'h05);
    for (int i = 0; i < 5; i++) putByte(8'h11);
    expectNoFrame("R2 wrong delimiter", bd, bi);
    bd = doneCnt; bi = irqCnt;
    for (int i = 0; i < 6; i++) putByte(8'h00);
    putByte(8'hA7); putByte(8'h05);
    for (int i = 0; i < 5; i++) putByte(8'h11);
    expectNoFrame("R2 six zeros", bd, bi);
    sendPre();                 // eight zeros in total with runFrame's own four
    runFrame(5, 0, 0, 0);

    // R3: bad lengths
    foreach (frm[i]) if (i < 2) frm[i] = 8'h11;
    bd = doneCnt; bi = irqCnt;
    sendPre(); putByte(8'hA7); putByte(8'h02);
    for (int i = 0; i < 3; i++) putByte(8'h11);
    expectNoFrame("R3 length 2", bd, bi);
    bd = doneCnt; bi = irqCnt;
    sendPre(); putByte(8'hA7); putByte(8'h80);
    for (int i = 0; i < 3; i++) putByte(8'h11);
    expectNoFrame("R3 length 128", bd, bi);
    runFrame(6, 0, 0, 0);

    // R8: overrun, then clear at next delimiter
    ackOn = 0;
    runFrame(6, 0, 1, 0);
    chk("R8 overrun set", overrun, 1);
    ackOn = 1;
    streamMode = 1'b1;
    sendPre(); putByte(8'hA7);
    #1;
    chk("R8 overrun cleared at delimiter", overrun, 0);
    putByte(8'h03);
    for (int i = 0; i < 3; i++) putByte(8'h22);
    repeat (WIN + 4) @(negedge clk);

    // R9: late peak outside the window is ignored
    bi = lqiCnt;
    linkLevel = 8'h33;
    streamMode = 1'b0;
    sendPre();
    repeat (WIN + 40) @(negedge clk);
    linkLevel = 8'h77;
    putByte(8'hA7); putByte(8'h04);
    for (int i = 0; i < 4; i++) putByte(8'h44);
    repeat (6) @(negedge clk);
    #1;
    chk("R9 peak inside window only", lqiValue, 8'h33);
    chk("R9 one window", lqiCnt - bi, 1);

    // random frames
    for (int n = 0; n < 14; n++) begin
      runFrame(3 + int'($urandom % 60), ($urandom % 3) == 0, 1'($urandom), 0);
    end

    summary();
  end

endmodule